// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, one frame at a time, whether an incoming Ethernet frame should be kept. A frame is presented for a single cycle as its 48-bit destination address, the CRC value computed over that address by an external generator, the frame length in bytes and two error flags (CRC mismatch, alignment error). One cycle later the block reports a decision strobe, an accept bit and a four-bit status word that the receive path records alongside the frame.

The block holds the station's own address, a 64-bit group hash table and six mode bits, all loaded through a small byte-wide configuration write port. Unicast frames pass on an exact address match or in promiscuous mode. Broadcast frames pass only when broadcast reception is enabled. Multicast frames pass only when multicast reception is enabled and the hashed table bit is set. Runt and errored frames are dropped unless their own override bit is set. An optional remote transmitter control lets two reserved hash slots switch a `txEnable` output off and on.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the station address, hash table and mode bits are all zero, `decValid` and `decAccept` are 0 and `txEnable` is 1. A write with `cfgWrEn` high stores `cfgWrData` at `cfgAddr`: addresses 0..5 hold station address bytes in wire order (address 0 is the first byte received, `frmDest[47:40]`), address 6 holds the mode bits, addresses 8..15 hold hash bytes 0..7. Mode bits: [0] keep errored, [1] keep runts, [2] take broadcast, [3] take multicast, [4] promiscuous, [5] remote transmitter control.
- R2: `decValid` is high exactly in the cycle after a cycle with `frmValid` high, and `decAccept` is never high without `decValid`.
- R3: A unicast destination (bit 40 of `frmDest` clear) passes the address test when the promiscuous bit is set or when it equals the station address.
- R4: The all-ones destination passes the address test only when the take-broadcast bit is set; it is never treated as multicast.
- R5: Any other destination with bit 40 set passes the address test only when the take-multicast bit is set and hash table bit `k` is 1, where `k` = `frmCrc[31:26]`; bits `k[5:3]` pick the hash byte and `k[2:0]` the bit in it.
- R6: A frame with `frmLen` below 64 is rejected unless the keep-runts bit is set.
- R7: A frame with `frmCrcErr` or `frmAlignErr` high is rejected unless the keep-errored bit is set.
- R8: `decStatus` bit 0 is 1 when neither error flag is set, bit 1 is 1 when either error flag is set, bit 2 copies the alignment error, and bit 3 is 1 for broadcast or multicast destinations and 0 for unicast. Status is reported whether or not the frame is accepted.
- R9: With the remote transmitter control bit set, an error-free multicast frame with hash index 62 clears `txEnable` and one with index 63 sets it, in the same cycle as its decision and regardless of the hash table and acceptance. Broadcast and errored frames leave it unchanged. With the bit clear, `txEnable` returns to 1 one cycle later.
- R10: A frame presented in the same cycle as a configuration write is judged with the configuration in force before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration byte address |
| cfgWrData | input | 8 | Configuration write data |
| frmValid | input | 1 | Frame descriptor present this cycle |
| frmDest | input | 48 | Destination address, first received byte in [47:40] |
| frmCrc | input | 32 | CRC over the destination address |
| frmLen | input | 11 | Frame length in bytes |
| frmCrcErr | input | 1 | Frame failed its CRC check |
| frmAlignErr | input | 1 | Frame ended off a byte boundary |
| decValid | output | 1 | Decision present |
| decAccept | output | 1 | Frame should be kept |
| decStatus | output | 4 | Status word to record with the frame |
| txEnable | output | 1 | Transmitter permitted |

## Verification
Two functions can land in one cycle: a configuration write and a frame evaluation. The bench raises a mode write that turns promiscuous reception on in the very cycle it presents a unicast frame for another station, and expects that frame to be rejected while the next identical frame passes. The transmitter control update and the accept decision also share a cycle; the bench checks both outputs after one multicast frame with a reserved hash index.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Mode bits, declared MSB first: saveErr lands on bit 0.
  typedef struct packed {
    logic autoTxCtl;
    logic promisc;
    logic takeMcast;
    logic takeBcast;
    logic keepRunt;
    logic keepErr;
  } modeT;

  // Facts the datapath derives from the frame and configuration.
  typedef struct packed {
    logic isBcast;
    logic isMcast;
    logic stationHit;
    logic hashHit;
    logic isRunt;
    logic hasErr;
    logic txOffSlot;
    logic txOnSlot;
  } matchT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic acceptBit;
    logic groupBit;
    logic txClr;
    logic txSet;
  } strobeT;

  localparam int STAT_W   = 4;
  localparam int ST_CLEAN = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_ALIGN = 2;
  localparam int ST_GROUP = 3;

endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int CRC_W      = 32,
  parameter int LEN_W      = 11,
  parameter int MIN_LEN    = 64,
  parameter int CFG_AW     = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [CFG_AW-1:0]       cfgAddr,
  input  logic [7:0]              cfgWrData,
  input  logic [ADDR_BYTES*8-1:0] frmDest,
  input  logic [CRC_W-1:0]        frmCrc,
  input  logic [LEN_W-1:0]        frmLen,
  input  logic                    frmCrcErr,
  input  logic                    frmAlignErr,
  input  strobeT                  strobes,
  output modeT                    modeQ,
  output matchT                   matchInfo,
  output logic                    decValid,
  output logic                    decAccept,
  output logic [STAT_W-1:0]       decStatus,
  output logic                    txEnable
);

  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int HASH_BYTES = HASH_BITS / 8;
  localparam int HASH_IDX_W = $clog2(HASH_BITS);
  localparam int MODE_ADDR  = ADDR_BYTES;
  localparam int HASH_BASE  = 2 ** (CFG_AW - 1);
  localparam int MODE_W     = $bits(modeT);

  logic [ADDR_BYTES-1:0] byteHit;
  logic [HASH_BITS-1:0]  hashFlat;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic                  unusedCrcLow;

  // Station address, one register per byte, compared in parallel.
  for (genvar gb = 0; gb < ADDR_BYTES; gb++) begin : g_sta
    logic [7:0] byteQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        byteQ <= '0;
      end else if (cfgWrEn && cfgAddr == CFG_AW'(gb)) begin
        byteQ <= cfgWrData;
      end
    end
    assign byteHit[gb] = (byteQ == frmDest[(ADDR_BYTES-1-gb)*8 +: 8]);
  end

  // Group hash table, byte k covers indexes k*8 .. k*8+7.
  for (genvar gh = 0; gh < HASH_BYTES; gh++) begin : g_hash
    logic [7:0] hashQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hashQ <= '0;
      end else if (cfgWrEn && cfgAddr == CFG_AW'(HASH_BASE + gh)) begin
        hashQ <= cfgWrData;
      end
    end
    assign hashFlat[gh*8 +: 8] = hashQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (cfgWrEn && cfgAddr == CFG_AW'(MODE_ADDR)) begin
      modeQ <= modeT'(cfgWrData[MODE_W-1:0]);
    end
  end

  assign hashIdx      = frmCrc[CRC_W-1 -: HASH_IDX_W];
  assign unusedCrcLow = ^frmCrc[CRC_W-HASH_IDX_W-1:0];

  always_comb begin
    matchInfo            = '0;
    matchInfo.isBcast    = &frmDest;
    matchInfo.isMcast    = frmDest[ADDR_W-8] & ~(&frmDest);
    matchInfo.stationHit = &byteHit;
    matchInfo.hashHit    = hashFlat[hashIdx];
    matchInfo.isRunt     = frmLen < LEN_W'(MIN_LEN);
    matchInfo.hasErr     = frmCrcErr | frmAlignErr;
    matchInfo.txOffSlot  = hashIdx == HASH_IDX_W'(HASH_BITS - 2);
    matchInfo.txOnSlot   = hashIdx == HASH_IDX_W'(HASH_BITS - 1);
  end

  // Decision and status registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decStatus <= '0;
    end else begin
      decValid <= strobes.capture;
      if (strobes.capture) begin
        decAccept           <= strobes.acceptBit;
        decStatus[ST_CLEAN] <= ~(frmCrcErr | frmAlignErr);
        decStatus[ST_ERR]   <= frmCrcErr | frmAlignErr;
        decStatus[ST_ALIGN] <= frmAlignErr;
        decStatus[ST_GROUP] <= strobes.groupBit;
      end else begin
        decAccept <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnable <= 1'b1;
    end else if (strobes.txClr) begin
      txEnable <= 1'b0;
    end else if (strobes.txSet) begin
      txEnable <= 1'b1;
    end
  end

endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
(
  input  logic   frmValid,
  input  modeT   modeQ,
  input  matchT  matchInfo,
  output strobeT strobes
);

  logic addrOk;
  logic lenOk;
  logic errOk;
  logic txCtlFrame;

  always_comb begin
    // Broadcast outranks multicast, which outranks unicast.
    if (matchInfo.isBcast) begin
      addrOk = modeQ.takeBcast;
    end else if (matchInfo.isMcast) begin
      addrOk = modeQ.takeMcast & matchInfo.hashHit;
    end else begin
      addrOk = modeQ.promisc | matchInfo.stationHit;
    end
    lenOk = ~matchInfo.isRunt | modeQ.keepRunt;
    errOk = ~matchInfo.hasErr | modeQ.keepErr;
    txCtlFrame = frmValid & modeQ.autoTxCtl & matchInfo.isMcast & ~matchInfo.hasErr;

    strobes           = '0;
    strobes.capture   = frmValid;
    strobes.acceptBit = addrOk & lenOk & errOk;
    strobes.groupBit  = matchInfo.isBcast | matchInfo.isMcast;
    strobes.txClr     = txCtlFrame & matchInfo.txOffSlot;
    strobes.txSet     = ~modeQ.autoTxCtl | (txCtlFrame & matchInfo.txOnSlot);
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int CRC_W      = 32,
  parameter int LEN_W      = 11,
  parameter int MIN_LEN    = 64,
  parameter int CFG_AW     = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [CFG_AW-1:0]       cfgAddr,
  input  logic [7:0]              cfgWrData,
  input  logic                    frmValid,
  input  logic [ADDR_BYTES*8-1:0] frmDest,
  input  logic [CRC_W-1:0]        frmCrc,
  input  logic [LEN_W-1:0]        frmLen,
  input  logic                    frmCrcErr,
  input  logic                    frmAlignErr,
  output logic                    decValid,
  output logic                    decAccept,
  output logic [STAT_W-1:0]       decStatus,
  output logic                    txEnable
);

  modeT   modeQ;
  matchT  matchInfo;
  strobeT strobes;

  rxf_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .CRC_W(CRC_W),
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .CFG_AW(CFG_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .frmDest(frmDest), .frmCrc(frmCrc), .frmLen(frmLen),
    .frmCrcErr(frmCrcErr), .frmAlignErr(frmAlignErr),
    .strobes(strobes), .modeQ(modeQ), .matchInfo(matchInfo),
    .decValid(decValid), .decAccept(decAccept),
    .decStatus(decStatus), .txEnable(txEnable)
  );

  rxf_control u_ctl (
    .frmValid(frmValid), .modeQ(modeQ),
    .matchInfo(matchInfo), .strobes(strobes)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
  import rxf_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              frmValid,
  input logic [ADDR_W-1:0] frmDest,
  input logic [LEN_W-1:0]  frmLen,
  input logic              frmCrcErr,
  input logic              frmAlignErr,
  input logic              decValid,
  input logic              decAccept,
  input logic              txEnable,
  input modeT              modeQ
);

  // R2
  dec_follows_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> decValid);

  // R2
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frmValid |=> !decValid);

  // R2
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> decValid);

  // R4
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && (&frmDest) && !modeQ.takeBcast) |=> !decAccept);

  // R6
  runt_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmLen < LEN_W'(MIN_LEN) && !modeQ.keepRunt) |=> !decAccept);

  // R7
  err_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && (frmCrcErr || frmAlignErr) && !modeQ.keepErr) |=> !decAccept);

  // R9
  tx_off_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnable) |-> ($past(frmValid) && $past(modeQ.autoTxCtl)));

endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .ADDR_W(ADDR_BYTES * 8), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmDest(frmDest),
  .frmLen(frmLen), .frmCrcErr(frmCrcErr), .frmAlignErr(frmAlignErr),
  .decValid(decValid), .decAccept(decAccept), .txEnable(txEnable),
  .modeQ(modeQ)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        frmValid = 1'b0;
  logic [47:0] frmDest = '0;
  logic [31:0] frmCrc = '0;
  logic [10:0] frmLen = '0;
  logic        frmCrcErr = 1'b0;
  logic        frmAlignErr = 1'b0;
  logic        decValid;
  logic        decAccept;
  logic [3:0]  decStatus;
  logic        txEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_56;
  localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_57;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MCAST   = 48'h01_00_5E_00_00_01;

  logic [63:0] hashModel;

  always #5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .frmValid(frmValid), .frmDest(frmDest),
    .frmCrc(frmCrc), .frmLen(frmLen), .frmCrcErr(frmCrcErr),
    .frmAlignErr(frmAlignErr), .decValid(decValid), .decAccept(decAccept),
    .decStatus(decStatus), .txEnable(txEnable)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendFrame(input logic [47:0] d, input logic [5:0] idx,
                           input int len, input bit ce, input bit ae);
    @(negedge clk);
    frmValid = 1'b1; frmDest = d; frmCrc = {idx, 26'h15A_5A5A};
    frmLen = 11'(len); frmCrcErr = ce; frmAlignErr = ae;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 decValid", int'(decValid), 0);
    check("R1 decAccept", int'(decAccept), 0);
    check("R1 txEnable", int'(txEnable), 1);
    // R1 zero station address matches an all-zero unicast destination
    sendFrame(48'h0, 6'd0, 64, 0, 0);
    check("R1 zero station", int'(decAccept), 1);
    check("R2 decValid", int'(decValid), 1);
    @(negedge clk);
    check("R2 decValid drops", int'(decValid), 0);

    for (int b = 0; b < 6; b++) cfgWrite(4'(b), STATION[(5-b)*8 +: 8]);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] hb;
      hb = (k == 0) ? 8'h20 : (8'h3C ^ 8'(k));
      hashModel[k*8 +: 8] = hb;
      cfgWrite(4'(8 + k), hb);
    end

    // Sweep of every mode against every frame kind, length and error case.
    for (int m = 0; m < 64; m++) begin
      cfgWrite(4'd6, 8'(m));
      for (int kind = 0; kind < 5; kind++) begin
        for (int li = 0; li < 2; li++) begin
          for (int ei = 0; ei < 3; ei++) begin
            logic [47:0] d;
            logic [5:0] idx;
            bit ce, ae, addrOk, grp, expAcc;
            int len;
            string req;
            idx = 6'd0;
            case (kind)
              0: d = STATION;
              1: d = OTHER;
              2: d = BCAST;
              3: begin d = MCAST; idx = 6'd5; end
              default: begin d = MCAST; idx = 6'd4; end
            endcase
            len = (li == 1) ? 64 : 63;
            ce = (ei == 1);
            ae = (ei == 2);
            sendFrame(d, idx, len, ce, ae);
            grp = (kind >= 2);
            if (kind == 2) addrOk = m[2];
            else if (kind >= 3) addrOk = m[3] && hashModel[idx];
            else addrOk = m[4] || (kind == 0);
            expAcc = addrOk && (len >= 64 || m[1]) && (!(ce || ae) || m[0]);
            if (ce || ae) req = "R7";
            else if (len < 64) req = "R6";
            else if (kind == 2) req = "R4";
            else if (kind >= 3) req = "R5";
            else req = "R3";
            check({req, " accept"}, int'(decAccept), int'(expAcc));
            check("R8 status", int'(decStatus),
                  int'({grp, ae, ce || ae, !(ce || ae)}));
          end
        end
      end
    end

    // R10 mode write and frame in one cycle: old mode judges the frame.
    cfgWrite(4'd6, 8'h00);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'd6; cfgWrData = 8'h10;
    frmValid = 1'b1; frmDest = OTHER; frmCrc = '0; frmLen = 11'd64;
    frmCrcErr = 1'b0; frmAlignErr = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; frmValid = 1'b0;
    check("R10 same-cycle frame", int'(decAccept), 0);
    sendFrame(OTHER, 6'd0, 64, 0, 0);
    check("R10 next frame", int'(decAccept), 1);

    // R9 remote transmitter control, with multicast reception on.
    cfgWrite(4'd6, 8'h28);
    sendFrame(BCAST, 6'd62, 64, 0, 0);
    check("R9 bcast ignored", int'(txEnable), 1);
    sendFrame(MCAST, 6'd62, 64, 0, 0);
    check("R9 off slot", int'(txEnable), 0);
    check("R5 hash miss slot 62", int'(decAccept), int'(hashModel[62]));
    sendFrame(MCAST, 6'd63, 64, 1, 0);
    check("R9 errored ignored", int'(txEnable), 0);
    sendFrame(MCAST, 6'd63, 64, 0, 0);
    check("R9 on slot", int'(txEnable), 1);
    sendFrame(MCAST, 6'd62, 64, 0, 0);
    check("R9 off again", int'(txEnable), 0);
    cfgWrite(4'd6, 8'h08);
    @(negedge clk);
    check("R9 option cleared", int'(txEnable), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule